// File: doc/BRIEF.md
# Comparator Event and Fault Controller

This block is the digital back end of an external analog comparator. It takes the raw comparator decision bit, moves it into the system clock domain through a flop synchronizer, and can invert it. It then watches the result for a programmable edge: rising, falling or both. A detected edge sets a sticky edge flag, which is cleared by reading the status register. The flag can raise an interrupt when the interrupt mask bit allows it. A fault output can be driven either by the sticky flag or by the live synchronized level, or held low.

Software controls the block through a simple 32-bit register bus with single-cycle write and read strobes. The input-select codes, the comparator enable and the analog trim fields (bias current and hysteresis) are driven out on ports to the analog macro. A status bit tells software that a mode write may have produced a spurious edge. A control-register write resets all the state to its defaults.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, the select, enable and trim outputs are 0, and `irq` and `fault` are 0.
- R2: The mode register at offset 0x04 keeps only the bits in mask 0x00007777 and reads back that masked value. Its fields are: bits 2:0 minus-input select, bits 6:4 plus-input select, bit 8 comparator enable, bits 10:9 edge type, bit 12 invert, bit 13 fault source, bit 14 fault enable. The select and enable fields are driven out on `neg_sel`, `pos_sel` and `cmp_en_o`.
- R3: `cmp_raw` passes through two synchronizing flops. A change of `cmp_raw` before clock edge k shows in status bit 1 after edge k+1 and not after edge k. Status bit 1 carries the synchronized level after optional inversion.
- R4: Edge type 0 flags only rising edges, 1 only falling edges, 2 both edges, and 3 no edges. The edge flag is status bit 0 at offset 0x30 and appears one cycle after the synchronized level changes.
- R5: With invert (mode bit 12) set, the synchronized level is complemented before edge detection and before it is reported in status bit 1.
- R6: The edge flag stays set until the status register is read, and the read clears it. If an edge is detected in the same cycle as the status read, the flag stays set.
- R7: While comparator enable is 0, no edge sets the flag.
- R8: A write with bit 0 set to offset 0x24 sets the interrupt mask (bit 0 of offset 0x2C). The same write to 0x28 clears it. Writes with bit 0 clear change nothing. `irq` is high exactly when the flag and the mask are both 1.
- R9: With fault enable at 0, `fault` is 0. With it at 1, `fault` follows the edge flag when fault source is 0, and the reported synchronized level when fault source is 1.
- R10: Writing 1 to bit 0 of offset 0x00 returns the mode, mask, trim, edge flag and spurious-edge bit to their reset values in the next cycle.
- R11: The analog register at offset 0x94 keeps bits 2:0 and reads them back. Bit 0 (0 = low power, 1 = high speed) drives `drive_cur`, and bits 2:1 drive `hyst_sel`.
- R12: Status bit 31 is set by a mode write that changes a select field, the enable or the invert bit. A write that changes none of them leaves it alone. A status read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cmp_raw | input | 1 | Asynchronous comparator decision bit |
| neg_sel | output | 3 | Minus-input select to the analog mux |
| pos_sel | output | 3 | Plus-input select to the analog mux |
| cmp_en_o | output | 1 | Comparator enable to the analog macro |
| drive_cur | output | 1 | Bias current select |
| hyst_sel | output | 2 | Hysteresis select |
| irq | output | 1 | Interrupt request |
| fault | output | 1 | Fault signal to downstream protection logic |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never both high, and that `cmp_raw` is a clean level as seen at the clock edge, so the synchronizer latency check can compare exact delayed copies. The bench drives the bus and `cmp_raw` only on the falling clock edge. It issues one access at a time, and after each comparator change it waits the full synchronizer and flag latency before reading the status. The one deliberate exception is the test that lines a status read up with the cycle in which an edge is detected.

// File: rtl/cev_pkg.sv
// Package: register offsets, masks and the decoded mode record shared by
// the comparator event controller. Assumes byte addressing on the bus.
package cev_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_IDIS  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ANA   = 8'h94;

    localparam logic [DATA_W-1:0] MODE_MASK  = 32'h0000_7777;
    localparam logic [DATA_W-1:0] SPUR_MASK  = 32'h0000_1177;
    localparam logic [DATA_W-1:0] ANA_MASK   = 32'h0000_0007;

    typedef enum logic [1:0] {
        EDG_RISE = 2'd0,
        EDG_FALL = 2'd1,
        EDG_BOTH = 2'd2,
        EDG_NONE = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic [2:0] neg_sel;
        logic [2:0] pos_sel;
        logic       en;
        edge_sel_e  etype;
        logic       inv;
        logic       fsrc;
        logic       fen;
    } cev_mode_t;

    // Unpack the stored mode word into named fields.
    function automatic cev_mode_t decode_mode(input logic [DATA_W-1:0] w);
        cev_mode_t m;
        m.neg_sel = w[2:0];
        m.pos_sel = w[6:4];
        m.en      = w[8];
        m.etype   = edge_sel_e'(w[10:9]);
        m.inv     = w[12];
        m.fsrc    = w[13];
        m.fen     = w[14];
        return m;
    endfunction

endpackage

// File: rtl/cev_sync.sv
// Module: cev_sync
// Multi-flop synchronizer for a single asynchronous bit.
// Assumes the input is a level that holds for several clock periods.
module cev_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cev_edge.sv
// Module: cev_edge
// Applies optional inversion to the synchronized level, then detects the
// selected edge and keeps a sticky flag. An edge wins over a same-cycle
// clear-on-read; a software reset wins over both.
// Assumes lvl_in is already synchronous to clk.
module cev_edge
    import cev_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      soft_clr,
    input  logic      lvl_in,
    input  logic      invert,
    input  logic      enable,
    input  edge_sel_e etype,
    input  logic      rd_clr,
    output logic      lvl_out,
    output logic      hit,
    output logic      flag
);

    logic prev_q;

    assign lvl_out = lvl_in ^ invert;

    // Remember the previous processed level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_out;
    end

    // Match the processed level transition against the selected edge type.
    always_comb begin
        hit = 1'b0;
        if (enable) begin
            unique case (etype)
                EDG_RISE: hit =  lvl_out & ~prev_q;
                EDG_FALL: hit = ~lvl_out &  prev_q;
                EDG_BOTH: hit =  lvl_out ^  prev_q;
                default:  hit = 1'b0;
            endcase
        end
    end

    // Sticky edge flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) flag <= 1'b0;
        else if (hit)           flag <= 1'b1;
        else if (rd_clr)        flag <= 1'b0;
    end

endmodule

// File: rtl/cev_regs.sv
// Module: cev_regs
// Register file: mode, interrupt mask, analog trim and the spurious-edge
// status bit, plus the read multiplexer and the strobes that other logic
// needs (software reset, status read).
// Assumes bus_wr and bus_rd are never high together.
module cev_regs
    import cev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              edge_flag,
    input  logic              lvl,
    output cev_mode_t         mode,
    output logic              irq_mask,
    output logic              ana_cur,
    output logic [1:0]        ana_hyst,
    output logic              soft_rst,
    output logic              stat_rd
);

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] mode_nx;
    logic [2:0]        ana_q;
    logic              spur_q;
    logic              mode_wr;

    assign mode_wr  = bus_wr && (bus_addr == OFS_MODE);
    assign soft_rst = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
    assign stat_rd  = bus_rd && (bus_addr == OFS_STAT);
    assign mode_nx  = bus_wdata & MODE_MASK;
    assign mode     = decode_mode(mode_q);
    assign ana_cur  = ana_q[0];
    assign ana_hyst = ana_q[2:1];

    // Mode word storage, masked to the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) mode_q <= '0;
        else if (mode_wr)       mode_q <= mode_nx;
    end

    // Analog trim storage.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                   ana_q <= '0;
        else if (bus_wr && bus_addr == OFS_ANA)   ana_q <= bus_wdata[2:0];
    end

    // Interrupt mask: enable write sets, disable write clears, zeros ignored.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                                  irq_mask <= 1'b0;
        else if (bus_wr && bus_addr == OFS_IEN  && bus_wdata[0]) irq_mask <= 1'b1;
        else if (bus_wr && bus_addr == OFS_IDIS && bus_wdata[0]) irq_mask <= 1'b0;
    end

    // Spurious-edge indicator: set on a mode write that moves a sensitive field.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            spur_q <= 1'b0;
        else if (mode_wr && ((mode_nx & SPUR_MASK) != (mode_q & SPUR_MASK)))
            spur_q <= 1'b1;
        else if (stat_rd)
            spur_q <= 1'b0;
    end

    // Read multiplexer; write-only and unmapped offsets read as zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_MODE:  bus_rdata = mode_q;
            OFS_IMASK: bus_rdata[0] = irq_mask;
            OFS_STAT:  bus_rdata = {spur_q, 29'b0, lvl, edge_flag};
            OFS_ANA:   bus_rdata[2:0] = ana_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_evt_ctrl.sv
// Module: cmp_evt_ctrl (top)
// Digital back end of an analog comparator: synchronizer, edge detector with
// sticky flag, register file, interrupt and fault output selection.
// Assumes a single clock domain for the bus; only cmp_raw is asynchronous.
module cmp_evt_ctrl
    import cev_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_raw,
    output logic [2:0]        neg_sel,
    output logic [2:0]        pos_sel,
    output logic              cmp_en_o,
    output logic              drive_cur,
    output logic [1:0]        hyst_sel,
    output logic              irq,
    output logic              fault
);

    cev_mode_t mode;
    logic      sync_q;
    logic      lvl;
    logic      edge_hit;
    logic      edge_flag;
    logic      irq_mask;
    logic      soft_rst;
    logic      stat_rd;

    cev_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (sync_q)
    );

    cev_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_rst),
        .lvl_in   (sync_q),
        .invert   (mode.inv),
        .enable   (mode.en),
        .etype    (mode.etype),
        .rd_clr   (stat_rd),
        .lvl_out  (lvl),
        .hit      (edge_hit),
        .flag     (edge_flag)
    );

    cev_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_flag (edge_flag),
        .lvl       (lvl),
        .mode      (mode),
        .irq_mask  (irq_mask),
        .ana_cur   (drive_cur),
        .ana_hyst  (hyst_sel),
        .soft_rst  (soft_rst),
        .stat_rd   (stat_rd)
    );

    assign neg_sel  = mode.neg_sel;
    assign pos_sel  = mode.pos_sel;
    assign cmp_en_o = mode.en;
    assign irq      = edge_flag & irq_mask;

    // Fault source selection, gated by the fault enable.
    always_comb begin
        if (!mode.fen)      fault = 1'b0;
        else if (mode.fsrc) fault = lvl;
        else                fault = edge_flag;
    end

endmodule

// File: rtl/cev_checker.sv
// Module: cev_checker
// Temporal checks on the controller, bound into every cmp_evt_ctrl instance.
// Assumes cmp_raw is a clean level at each rising clock edge.
module cev_checker
    import cev_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_raw,
    input logic              sync_q,
    input logic              cmp_en_o,
    input logic              edge_hit,
    input logic              edge_flag,
    input logic              stat_rd,
    input logic              soft_rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_mask,
    input logic              fen,
    input logic              fault
);

    logic [1:0] age_q;

    // Count cycles since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2) age_q <= age_q + 2'd1;
    end

    assert_sync_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2) |-> (sync_q == $past(cmp_raw, 2)));

    assert_flag_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_flag) |-> $past(cmp_en_o));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !soft_rst) |=> edge_flag);

    assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !edge_hit) |=> !edge_flag);

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IEN && bus_wdata[0]) |=> irq_mask);

    assert_soft_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!edge_flag && !irq_mask && !cmp_en_o));

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fen |-> !fault);

endmodule

bind cmp_evt_ctrl cev_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_raw   (cmp_raw),
    .sync_q    (sync_q),
    .cmp_en_o  (cmp_en_o),
    .edge_hit  (edge_hit),
    .edge_flag (edge_flag),
    .stat_rd   (stat_rd),
    .soft_rst  (soft_rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_mask  (irq_mask),
    .fen       (mode.fen),
    .fault     (fault)
);

// File: tb/sim_cmp_evt_ctrl.sv
// Directed bench for cmp_evt_ctrl: one task per scenario, each self-checking.
`timescale 1ns/1ps
module sim_cmp_evt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmp_raw = 1'b0;
    logic [2:0]  neg_sel, pos_sel;
    logic        cmp_en_o, drive_cur, irq, fault;
    logic [1:0]  hyst_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_IEN = 8'h24,
                           A_IDIS = 8'h28, A_MASK = 8'h2C, A_STAT = 8'h30,
                           A_ANA = 8'h94;

    always #2.5 clk = ~clk;

    cmp_evt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_raw(cmp_raw), .neg_sel(neg_sel), .pos_sel(pos_sel),
        .cmp_en_o(cmp_en_o), .drive_cur(drive_cur), .hyst_sel(hyst_sel),
        .irq(irq), .fault(fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle(input logic v);
        logic [31:0] d;
        cmp_raw = v;
        tick(3);
        rd(A_STAT, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_MODE, d); chk("R1 mode", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_ANA, d);  chk("R1 analog", d, 0);
        chk("R1 outputs", {neg_sel, pos_sel, cmp_en_o, drive_cur, hyst_sel, irq, fault}, 0);
    endtask

    task automatic t_mode_rw();
        logic [31:0] d;
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, d); chk("R2 masked readback", d, 32'h7777);
        chk("R2 select/enable pins", {neg_sel, pos_sel, cmp_en_o}, {3'd7, 3'd7, 1'b1});
        wr(A_MODE, 32'h0000_0025);
        chk("R2 select split", {neg_sel, pos_sel, cmp_en_o}, {3'd5, 3'd2, 1'b0});
        wr(A_MODE, 0);
        settle(1'b0);
        rd(A_STAT, d);
    endtask

    task automatic t_analog();
        logic [31:0] d;
        wr(A_ANA, 32'hFFFF_FFFF);
        rd(A_ANA, d); chk("R11 analog readback", d, 7);
        chk("R11 trim pins", {drive_cur, hyst_sel}, 3'b111);
        wr(A_ANA, 32'h2);
        chk("R11 trim split", {drive_cur, hyst_sel}, 3'b001);
        wr(A_ANA, 0);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        wr(A_MODE, 32'h100);
        settle(1'b0);
        rd(A_STAT, d);
        cmp_raw = 1'b1;
        tick(1);
        rd(A_STAT, d); chk("R3 level not yet through", d[1], 0);
        rd(A_STAT, d); chk("R3 level after two flops", d[1], 1);
        settle(1'b0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        for (int code = 0; code < 4; code++) begin
            wr(A_MODE, 32'h100 | (code << 9));
            settle(1'b0);
            rd(A_STAT, d);
            cmp_raw = 1'b1; tick(3);
            rd(A_STAT, d);
            chk($sformatf("R4 rise type %0d", code), d[0], (code == 0 || code == 2));
            cmp_raw = 1'b0; tick(3);
            rd(A_STAT, d);
            chk($sformatf("R4 fall type %0d", code), d[0], (code == 1 || code == 2));
        end
    endtask

    task automatic t_invert();
        logic [31:0] d;
        wr(A_MODE, 32'h1100);
        tick(3);
        rd(A_STAT, d); chk("R5 inverted low reads high", d[1], 1);
        rd(A_STAT, d);
        cmp_raw = 1'b1; tick(3);
        rd(A_STAT, d); chk("R5 inverted rise is a fall", d[1:0], 2'b00);
        cmp_raw = 1'b0; tick(3);
        rd(A_STAT, d); chk("R5 inverted fall flags rise", d[1:0], 2'b11);
        wr(A_MODE, 32'h100);
        settle(1'b0);
        rd(A_STAT, d);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        cmp_raw = 1'b1; tick(6);
        rd(A_STAT, d); chk("R6 flag holds", d[0], 1);
        rd(A_STAT, d); chk("R6 cleared by read", d[0], 0);
        settle(1'b0);
        cmp_raw = 1'b1; tick(2);
        rd(A_STAT, d); chk("R6 collision read sees old", d[0], 0);
        rd(A_STAT, d); chk("R6 edge beats clear", d[0], 1);
        rd(A_STAT, d); chk("R6 cleared afterwards", d[0], 0);
        settle(1'b0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(A_MODE, 32'h400);
        settle(1'b0);
        cmp_raw = 1'b1; tick(3);
        rd(A_STAT, d); chk("R7 no flag on rise when off", d[0], 0);
        cmp_raw = 1'b0; tick(3);
        rd(A_STAT, d); chk("R7 no flag on fall when off", d[0], 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_MODE, 32'h100);
        settle(1'b0);
        wr(A_IEN, 0);
        rd(A_MASK, d); chk("R8 enable zero ignored", d, 0);
        wr(A_IEN, 1);
        rd(A_MASK, d); chk("R8 enable sets mask", d, 1);
        wr(A_IEN, 0);
        chk("R8 no irq without flag", irq, 0);
        cmp_raw = 1'b1; tick(3);
        chk("R8 irq on flag and mask", irq, 1);
        wr(A_IDIS, 0);
        rd(A_MASK, d); chk("R8 disable zero ignored", d, 1);
        wr(A_IDIS, 1);
        chk("R8 irq off when masked", irq, 0);
        rd(A_MASK, d); chk("R8 disable clears mask", d, 0);
        rd(A_STAT, d); chk("R8 flag kept while masked", d[0], 1);
        settle(1'b0);
    endtask

    task automatic t_fault();
        logic [31:0] d;
        wr(A_MODE, 32'h100);
        settle(1'b0);
        cmp_raw = 1'b1; tick(3);
        chk("R9 fault off when disabled", fault, 0);
        wr(A_MODE, 32'h4100);
        chk("R9 fault follows flag", fault, 1);
        rd(A_STAT, d);
        chk("R9 fault drops with flag", fault, 0);
        wr(A_MODE, 32'h6100);
        chk("R9 fault follows level high", fault, 1);
        cmp_raw = 1'b0; tick(2);
        chk("R9 fault follows level low", fault, 0);
        wr(A_MODE, 32'h100);
        settle(1'b0);
    endtask

    task automatic t_spur();
        logic [31:0] d;
        wr(A_MODE, 32'h100);
        rd(A_STAT, d);
        wr(A_MODE, 32'h110);
        rd(A_STAT, d); chk("R12 set on select change", d[31], 1);
        rd(A_STAT, d); chk("R12 cleared by read", d[31], 0);
        wr(A_MODE, 32'h110);
        rd(A_STAT, d); chk("R12 unchanged write", d[31], 0);
        wr(A_MODE, 32'h510);
        rd(A_STAT, d); chk("R12 edge type only", d[31], 0);
    endtask

    task automatic t_swrst();
        logic [31:0] d;
        wr(A_MODE, 32'h6177);
        wr(A_ANA, 7);
        wr(A_IEN, 1);
        cmp_raw = 1'b1; tick(3);
        chk("R10 irq before reset", irq, 1);
        wr(A_CTRL, 1);
        rd(A_MODE, d); chk("R10 mode cleared", d, 0);
        rd(A_MASK, d); chk("R10 mask cleared", d, 0);
        rd(A_ANA, d);  chk("R10 analog cleared", d, 0);
        rd(A_STAT, d); chk("R10 status keeps only level", d, 32'h2);
        chk("R10 pins cleared", {cmp_en_o, irq, fault, drive_cur}, 0);
        settle(1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mode_rw();
        t_analog();
        t_sync();
        t_edges();
        t_invert();
        t_sticky();
        t_disable();
        t_irq();
        t_fault();
        t_spur();
        t_swrst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule